// File: doc/BRIEF.md
# Device Control Register Bank

This block is the register front end of a paravirtual RDMA-style PCI function. Software reaches it over a plain 32-bit register bus made of an address, write data, a write strobe, a read strobe and registered read data with a valid flag. The bank holds a version word, an error/status word, an interrupt mask, a control word, a command request word and a 64-bit pointer to a shared region in host memory. The pointer is written as two 32-bit halves.

Writes have side effects. Writing the upper pointer half completes the pointer. One cycle later it raises a load pulse, and a capability-initialise pulse follows in the cycle after that. A write to the control word with a known code raises one of three lifecycle pulses: start, resume or halt. The start code also clears the error word. A zero written to the request word raises a command-execute pulse. The logic that walks the shared region and executes commands sits outside and consumes these pulses. The interrupt mask gates a vector of interrupt requests. Two 64-bit counters tally every read and every write access.

Top module: `devctl_regbank`

## Requirements
- R1: After reset the version word reads HW_VERSION, the error word reads 0x0000FFFF, and every other word, both counters and all pulses read 0.
- R2: A read strobe in one cycle gives bus_rvalid high and bus_rdata holding the addressed word in the next cycle, and only in that cycle. A written value reads back unchanged. Word offsets: version 0x00, pointer low 0x04, pointer high 0x08, control 0x0C, request 0x10, error 0x14, interrupt mask 0x18.
- R3: A write to pointer low (0x04) sets region_addr to the written value zero-extended to 64 bits, so the upper half becomes 0.
- R4: A write to pointer high (0x08) ORs the value into region_addr[63:32]. region_load is high for exactly the cycle after the write. region_caps_init is high for exactly the cycle after that.
- R5: A control write (0x0C) of 0 raises dev_start for one cycle and clears the error word to 0. A value of 1 raises dev_resume, and a value of 2 raises dev_halt. Any other value raises no pulse and leaves the error word unchanged.
- R6: A write to request (0x10) raises cmd_exec for one cycle only when the value is 0. A nonzero value is stored and raises nothing.
- R7: irq_out is irq_req with every bit cleared whose interrupt-mask bit is 1. The mask has bit i for request i.
- R8: rd_count increments by one for each cycle with bus_re high, and wr_count increments by one for each cycle with bus_we high. This includes accesses that miss the register map.
- R9: An access to an unaligned address or an offset at or above 0x1C raises bus_err for one cycle in the next cycle. A read then returns 0xFFFFFFFF, and no register or pulse changes.
- R10: With bus_re and bus_we high in the same cycle on the same word, the read returns the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| bus_err | output | 1 | Access missed the register map |
| irq_req | input | NIRQ | Raw interrupt requests |
| irq_out | output | NIRQ | Requests left after the mask |
| region_addr | output | 64 | Shared-region pointer |
| region_load | output | 1 | Pulse: pointer complete, load region |
| region_caps_init | output | 1 | Pulse: fill in capabilities |
| dev_start | output | 1 | Pulse: start device |
| dev_resume | output | 1 | Pulse: resume device |
| dev_halt | output | 1 | Pulse: halt device |
| cmd_exec | output | 1 | Pulse: execute command |
| rd_count | output | CNT_W | Read access counter |
| wr_count | output | CNT_W | Write access counter |

## Verification
A read and a write can land on the bus in the same cycle. When both hit the same word, the two paths contend for one storage element. The bench raises both strobes in one cycle on the request word, which already holds a known value. It expects the old value in the returned data, the new value on a later plain read, and both counters advanced by one. The same collision on a miss address must give 0xFFFFFFFF and a single error pulse.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  localparam int NREG = 7;
  typedef enum logic [2:0] {
    REG_VER = 3'd0,
    REG_RLO = 3'd1,
    REG_RHI = 3'd2,
    REG_CTL = 3'd3,
    REG_REQ = 3'd4,
    REG_ERR = 3'd5,
    REG_MSK = 3'd6
  } reg_idx_t;
  localparam logic [31:0] CTL_START  = 32'd0;
  localparam logic [31:0] CTL_RESUME = 32'd1;
  localparam logic [31:0] CTL_HALT   = 32'd2;
  localparam logic [31:0] ERR_INIT   = 32'h0000_FFFF;
  localparam logic [31:0] MISS_DATA  = 32'hFFFF_FFFF;
endpackage

// File: rtl/devctl_decode.sv
module devctl_decode #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic                         hit,
  output devctl_pkg::reg_idx_t         idx,
  output logic [devctl_pkg::NREG-1:0]  sel
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] word;
  assign word = addr[ADDR_W-1:2];
  assign hit  = (addr[1:0] == 2'b00) && (word < IDX_W'(devctl_pkg::NREG));
  assign idx  = hit ? devctl_pkg::reg_idx_t'(word[2:0]) : devctl_pkg::REG_VER;

  for (genvar i = 0; i < devctl_pkg::NREG; i++) begin : g_sel
    assign sel[i] = hit && (word == IDX_W'(i));
  end
endmodule

// File: rtl/devctl_access_counter.sv
module devctl_access_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/devctl_lifecycle.sv
module devctl_lifecycle (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctl,
  input  logic        wr_rhi,
  input  logic        wr_req,
  input  logic [31:0] wdata,
  output logic        load_p,
  output logic        caps_p,
  output logic        start_p,
  output logic        resume_p,
  output logic        halt_p,
  output logic        cmd_p
);
  import devctl_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_p   <= 1'b0;
      caps_p   <= 1'b0;
      start_p  <= 1'b0;
      resume_p <= 1'b0;
      halt_p   <= 1'b0;
      cmd_p    <= 1'b0;
    end else begin
      load_p   <= wr_rhi;
      caps_p   <= load_p;
      start_p  <= wr_ctl && (wdata == CTL_START);
      resume_p <= wr_ctl && (wdata == CTL_RESUME);
      halt_p   <= wr_ctl && (wdata == CTL_HALT);
      cmd_p    <= wr_req && (wdata == 32'd0);
    end
  end
endmodule

// File: rtl/devctl_regbank.sv
module devctl_regbank #(
  parameter int          ADDR_W     = 5,
  parameter int          NIRQ       = 4,
  parameter int          CNT_W      = 64,
  parameter logic [31:0] HW_VERSION = 32'h0001_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic [NIRQ-1:0]   irq_req,
  output logic [NIRQ-1:0]   irq_out,
  output logic [63:0]       region_addr,
  output logic              region_load,
  output logic              region_caps_init,
  output logic              dev_start,
  output logic              dev_resume,
  output logic              dev_halt,
  output logic              cmd_exec,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  wr_count
);
  import devctl_pkg::*;

  logic            hit;
  reg_idx_t        idx;
  logic [NREG-1:0] sel, wsel;
  logic [31:0]     ver_q, ctl_q, req_q, err_q, msk_q, rd_mux;
  logic [63:0]     ptr_q;

  devctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx), .sel(sel)
  );

  assign wsel = sel & {NREG{bus_we}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ver_q <= HW_VERSION;
      ctl_q <= '0;
      req_q <= '0;
      err_q <= ERR_INIT;
      msk_q <= '0;
      ptr_q <= '0;
    end else begin
      if (wsel[REG_VER]) ver_q <= bus_wdata;
      if (wsel[REG_CTL]) ctl_q <= bus_wdata;
      if (wsel[REG_REQ]) req_q <= bus_wdata;
      if (wsel[REG_MSK]) msk_q <= bus_wdata;
      if (wsel[REG_ERR]) err_q <= bus_wdata;
      else if (wsel[REG_CTL] && bus_wdata == CTL_START) err_q <= '0;
      if (wsel[REG_RLO]) ptr_q <= {32'd0, bus_wdata};
      else if (wsel[REG_RHI]) ptr_q[63:32] <= ptr_q[63:32] | bus_wdata;
    end
  end

  always_comb begin
    unique case (idx)
      REG_VER: rd_mux = ver_q;
      REG_RLO: rd_mux = ptr_q[31:0];
      REG_RHI: rd_mux = ptr_q[63:32];
      REG_CTL: rd_mux = ctl_q;
      REG_REQ: rd_mux = req_q;
      REG_ERR: rd_mux = err_q;
      REG_MSK: rd_mux = msk_q;
      default: rd_mux = MISS_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      bus_err    <= (bus_re || bus_we) && !hit;
      if (bus_re) bus_rdata <= hit ? rd_mux : MISS_DATA;
    end
  end

  devctl_lifecycle u_life (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl(wsel[REG_CTL]), .wr_rhi(wsel[REG_RHI]), .wr_req(wsel[REG_REQ]),
    .wdata(bus_wdata),
    .load_p(region_load), .caps_p(region_caps_init),
    .start_p(dev_start), .resume_p(dev_resume), .halt_p(dev_halt),
    .cmd_p(cmd_exec)
  );

  devctl_access_counter #(.CNT_W(CNT_W)) u_rdcnt (
    .clk(clk), .rst_n(rst_n), .inc(bus_re), .count(rd_count)
  );
  devctl_access_counter #(.CNT_W(CNT_W)) u_wrcnt (
    .clk(clk), .rst_n(rst_n), .inc(bus_we), .count(wr_count)
  );

  assign region_addr = ptr_q;
  assign irq_out     = irq_req & ~msk_q[NIRQ-1:0];
endmodule

// File: rtl/devctl_regbank_checker.sv
module devctl_regbank_checker #(
  parameter int ADDR_W = 5,
  parameter int NIRQ   = 4,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic [NIRQ-1:0]   irq_req,
  input logic [NIRQ-1:0]   irq_out,
  input logic [63:0]       region_addr,
  input logic              region_load,
  input logic              region_caps_init,
  input logic              dev_start,
  input logic              dev_resume,
  input logic              dev_halt,
  input logic              cmd_exec,
  input logic [CNT_W-1:0]  rd_count,
  input logic [CNT_W-1:0]  wr_count
);
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);
  assert_no_spurious_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !bus_rvalid);
  assert_low_clears_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(4)) |=> region_addr[63:32] == 32'd0);
  assert_caps_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    region_load |=> region_caps_init);
  assert_lifecycle_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_start, dev_resume, dev_halt}));
  assert_cmd_zero_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(16) && bus_wdata != 32'd0) |=> !cmd_exec);
  assert_wr_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> wr_count == $past(wr_count) + CNT_W'(1));
  assert_rd_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(rd_count));
  assert_miss_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && bus_rvalid) |-> bus_rdata == 32'hFFFF_FFFF);
  assert_miss_holds_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && bus_addr >= ADDR_W'(28)) |=> $stable(region_addr));
endmodule

bind devctl_regbank devctl_regbank_checker #(
  .ADDR_W(ADDR_W), .NIRQ(NIRQ), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/devctl_regbank_test.sv
`timescale 1ns/1ps
module devctl_regbank_test;
  localparam int ADDR_W = 5;
  localparam int NIRQ = 4;
  localparam int CNT_W = 64;
  localparam logic [31:0] HWV = 32'h0001_0003;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, bus_err;
  logic [NIRQ-1:0] irq_req = '0, irq_out;
  logic [63:0] region_addr;
  logic region_load, region_caps_init, dev_start, dev_resume, dev_halt, cmd_exec;
  logic [CNT_W-1:0] rd_count, wr_count;

  int checks = 0, fails = 0;
  longint n_rd = 0, n_wr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  devctl_regbank #(.ADDR_W(ADDR_W), .NIRQ(NIRQ), .CNT_W(CNT_W), .HW_VERSION(HWV)) uut (.*);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    n_wr++;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk); #1;
    bus_re = 1'b0;
    n_rd++;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    check("R1 wr_count", wr_count, 0);
    check("R1 region", region_addr, 0);
    rd(5'h00, d, e); check("R1 version", d, HWV);
    rd(5'h14, d, e); check("R1 error", d, 32'h0000FFFF);
    rd(5'h18, d, e); check("R1 mask", d, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d; logic e;
    wr(5'h18, 32'hA5A5_0000);
    @(negedge clk); bus_addr = 5'h18; bus_re = 1'b1;
    @(posedge clk); #1; bus_re = 1'b0; n_rd++;
    check("R2 rvalid next cycle", bus_rvalid, 1);
    check("R2 readback", bus_rdata, 32'hA5A5_0000);
    @(posedge clk); #1;
    check("R2 rvalid drops", bus_rvalid, 0);
    wr(5'h18, 32'h0);
  endtask

  task automatic t_pointer;
    logic [31:0] d; logic e;
    wr(5'h08, 32'h0000_00F0);
    check("R4 load pulse", region_load, 1);
    check("R4 caps not yet", region_caps_init, 0);
    @(posedge clk); #1;
    check("R4 load one cycle", region_load, 0);
    check("R4 caps pulse", region_caps_init, 1);
    @(posedge clk); #1;
    check("R4 caps one cycle", region_caps_init, 0);
    wr(5'h08, 32'h0000_0F00);
    check("R4 OR into high", region_addr, 64'h0000_0FF0_0000_0000);
    wr(5'h04, 32'h1234_5678);
    check("R3 low replaces", region_addr, 64'h0000_0000_1234_5678);
    check("R3 no load pulse", region_load, 0);
    wr(5'h08, 32'hCAFE_0000);
    rd(5'h08, d, e); check("R2 high readback", d, 32'hCAFE_0000);
    rd(5'h04, d, e); check("R2 low readback", d, 32'h1234_5678);
  endtask

  task automatic t_control;
    logic [31:0] d; logic e;
    wr(5'h0C, 32'd7);
    check("R5 other code no pulse", {dev_start, dev_resume, dev_halt}, 0);
    rd(5'h14, d, e); check("R5 other code keeps error", d, 32'h0000FFFF);
    rd(5'h0C, d, e); check("R2 ctl readback", d, 7);
    wr(5'h0C, 32'd1);
    check("R5 resume", {dev_start, dev_resume, dev_halt}, 3'b010);
    wr(5'h0C, 32'd2);
    check("R5 halt", {dev_start, dev_resume, dev_halt}, 3'b001);
    rd(5'h14, d, e); check("R5 halt keeps error", d, 32'h0000FFFF);
    wr(5'h0C, 32'd0);
    check("R5 start", {dev_start, dev_resume, dev_halt}, 3'b100);
    @(posedge clk); #1;
    check("R5 start one cycle", dev_start, 0);
    rd(5'h14, d, e); check("R5 error cleared", d, 0);
    wr(5'h14, 32'h55);
    rd(5'h14, d, e); check("R2 error writable", d, 32'h55);
  endtask

  task automatic t_request;
    logic [31:0] d; logic e;
    wr(5'h10, 32'd9);
    check("R6 nonzero no exec", cmd_exec, 0);
    rd(5'h10, d, e); check("R6 nonzero stored", d, 9);
    wr(5'h10, 32'd0);
    check("R6 zero exec", cmd_exec, 1);
    @(posedge clk); #1;
    check("R6 exec one cycle", cmd_exec, 0);
  endtask

  task automatic t_irq;
    wr(5'h18, 32'h0000_0005);
    irq_req = 4'hF; #1;
    check("R7 masked", irq_out, 4'hA);
    irq_req = 4'h5; #1;
    check("R7 all masked", irq_out, 4'h0);
    wr(5'h18, 32'h0);
    irq_req = 4'h6; #1;
    check("R7 unmasked", irq_out, 4'h6);
    irq_req = '0;
  endtask

  task automatic t_miss;
    logic [31:0] d; logic e;
    rd(5'h1C, d, e);
    check("R9 miss data", d, 32'hFFFF_FFFF);
    check("R9 miss err", e, 1);
    @(posedge clk); #1;
    check("R9 err one cycle", bus_err, 0);
    wr(5'h06, 32'hFFFF_FFFF);
    check("R9 unaligned err", bus_err, 1);
    check("R9 no pulse", {region_load, cmd_exec, dev_start}, 0);
    check("R9 ptr unchanged", region_addr, 64'hCAFE_0000_1234_5678);
    rd(5'h04, d, e); check("R9 low unchanged", d, 32'h1234_5678);
    check("R9 hit no err", e, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d; logic e;
    wr(5'h10, 32'h11);
    @(negedge clk);
    bus_addr = 5'h10; bus_wdata = 32'h22; bus_we = 1'b1; bus_re = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b0; n_rd++; n_wr++;
    check("R10 old value read", bus_rdata, 32'h11);
    rd(5'h10, d, e); check("R10 write landed", d, 32'h22);
    @(negedge clk);
    bus_addr = 5'h1E; bus_wdata = 32'h1; bus_we = 1'b1; bus_re = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b0; n_rd++; n_wr++;
    check("R10 miss collide data", bus_rdata, 32'hFFFF_FFFF);
    check("R10 miss collide err", bus_err, 1);
  endtask

  task automatic t_counters;
    @(negedge clk);
    check("R8 rd_count", rd_count, n_rd);
    check("R8 wr_count", wr_count, n_wr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_readback();
    t_pointer();
    t_control();
    t_request();
    t_irq();
    t_miss();
    t_collide();
    t_counters();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule